// File: doc/BRIEF.md
# Serial EEPROM Target Engine

This block is the target side of a four-wire serial memory link, mode 0 (clock idles low). The memory is byte-organised, with an address width set by a parameter. The serial pins are brought into the system clock domain and oversampled there. SI is taken on each rising SCK and SO changes after each falling SCK. SO is driven only while a read or status byte is being returned. Each transaction opens with an 8-bit command. Array accesses then take a 16-bit address, sent most significant bit first, of which only the low `ADDR_W` bits are kept.

Reads stream one byte after another from an incrementing pointer. Writes collect up to one page of bytes in a page staging buffer. When the host deselects on a clean byte boundary, the write-enable latch is set and the external protection unit grants permission, a timed internal write cycle copies the staged bytes into the array. A small configuration field can be written by its own command and is exported to the protection unit, which answers with two permission levels.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset `so_oe` and `busy` are 0, `prot_cfg` is 0 and the write-enable latch is clear. If CS is already low when reset is released, every clock is ignored until CS has gone high and then low again.
- R2: SI is sampled on rising SCK and SO changes after falling SCK, MSB first. `so_oe` is 0 during the command and address bits and 0 when deselected, and 1 while read or status data is returned.
- R3: Command 0x05 returns the status byte repeatedly. Bit 7 is `prot_cfg[2]`, bits 3:2 are `prot_cfg[1:0]`, bit 1 is the write-enable latch, bit 0 is `busy`, and bits 6:4 are 0.
- R4: Command 0x06 sets the write-enable latch and command 0x04 clears it. Either takes effect only when CS rises right after its eighth bit.
- R5: Command 0x02 followed by an address stores each complete data byte at the pointer. The pointer then advances within the current page of 2^PAGE_W bytes, wrapping from the last byte of the page to its first, so later bytes overwrite earlier ones.
- R6: A write commits only if CS rises right after bit 0 of a data byte, the latch is set and `arr_wr_ok` is 1. Otherwise the array and the latch stay unchanged and no cycle starts.
- R7: A committed write raises `busy` within 3 clocks of CS rising, holds it for WR_CYCLES clocks, and clears the write-enable latch.
- R8: Command 0x03 followed by an address returns bytes from successive addresses, rolling over from 2^ADDR_W-1 to 0. Address bits above ADDR_W-1 are ignored.
- R9: While `busy` is 1, every command except 0x05 is ignored: SO stays disabled and nothing changes.
- R10: Command 0x01 followed by exactly one byte loads bits 7, 3 and 2 of that byte into `prot_cfg[2:0]`. This happens only when the latch is set and `sts_wr_ok` is 1 when CS rises. It also runs a timed cycle and clears the latch.
- R11: An undefined command causes all further bits to be ignored until CS rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| busy | output | 1 | Internal write cycle running |
| arr_wr_ok | input | 1 | Protection unit allows the array write |
| sts_wr_ok | input | 1 | Protection unit allows the configuration write |
| prot_cfg | output | 3 | Stored protection configuration |

## Verification
A wrong command-phase state, such as a miscounted bit or a bad decode, shows up as a missing or misplaced `so_oe` within the next byte time. A corrupted pointer or page buffer stays hidden until the following read returns the wrong byte at a specific address, so every write scenario is followed by a read-back. Latch or cycle-control faults show up at once in the status byte, or as a `busy` pulse whose start or length is wrong.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  typedef enum logic [3:0] {
    ST_OPC, ST_ADDR, ST_RD, ST_WR, ST_SRD, ST_SWR, ST_SETW, ST_CLRW, ST_SKIP
  } ee_st_e;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_WDIS = 8'h04;
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_SRD  = 8'h05;
  localparam logic [7:0] OP_SWR  = 8'h01;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic sel,
  output logic desel_evt,
  output logic sck_up,
  output logic sck_dn,
  output logic si_s
);
  logic [2:0] cs_q, sck_q;
  logic [1:0] si_q;
  logic       armed, armed_n;

  // select only becomes valid after CS has been seen high once
  assign armed_n = armed | cs_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= '0;
      sck_q <= '0;
      si_q  <= '0;
      armed <= 1'b0;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      si_q  <= {si_q[0], si};
      armed <= armed_n;
    end
  end

  assign sel       = armed & ~cs_q[1];
  assign desel_evt = cs_q[1] & ~cs_q[2];
  assign sck_up    = sel & sck_q[1] & ~sck_q[2];
  assign sck_dn    = sel & ~sck_q[1] & sck_q[2];
  assign si_s      = si_q[1];
endmodule

// File: rtl/spi_ee_pgbuf.sv
module spi_ee_pgbuf #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [PW-1:0] ld_idx,
  input  logic [7:0]    ld_data,
  input  logic [PW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          rd_vld
);
  localparam int N = 1 << PW;

  logic [7:0]   slot [N];
  logic [N-1:0] vld, vld_n;

  always_comb begin
    vld_n = vld;
    if (clr) vld_n = '0;
    if (ld)  vld_n[ld_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (ld) slot[ld_idx] <= ld_data;
  end

  assign rd_data = slot[rd_idx];
  assign rd_vld  = vld[rd_idx];

  // R5: a byte loaded into the page buffer is marked for the commit
  a_r5_ld_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> vld[$past(ld_idx)]);
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 1250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  output logic       so,
  output logic       so_oe,
  output logic       busy,
  input  logic       arr_wr_ok,
  input  logic       sts_wr_ok,
  output logic [2:0] prot_cfg
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int WC   = (WR_CYCLES > PAGE) ? WR_CYCLES : PAGE + 1;
  localparam int CW   = $clog2(WC + 1);

  logic sel, desel_evt, sck_up, sck_dn, si_s;

  ee_st_e            st, st_n;
  logic [3:0]        bit_q, bit_n;
  logic [6:0]        in_q, in_n;
  logic [7:0]        byte_w;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic              wrop_q, wrop_n, done_q, done_n, wel_q, wel_n;
  logic [2:0]        cfg_q, cfg_n, stg_q, stg_n;
  logic              busy_q, busy_n, kind_q, kind_n;
  logic [CW-1:0]     cyc_q, cyc_n;
  logic [7:0]        tx_q, tx_n;
  logic [2:0]        txc_q, txc_n;
  logic              live_q, live_n;
  logic              pb_clr, pb_ld, pb_vld, mem_we, start_arr, start_sts, cyc_end;
  logic [7:0]        pb_data, rd_q, status;
  logic [ADDR_W-1:0] mem_waddr;

  spi_ee_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .sel(sel), .desel_evt(desel_evt), .sck_up(sck_up), .sck_dn(sck_dn), .si_s(si_s)
  );

  spi_ee_pgbuf #(.PW(PAGE_W)) u_pgbuf (
    .clk(clk), .rst_n(rst_n), .clr(pb_clr), .ld(pb_ld),
    .ld_idx(ptr_q[PAGE_W-1:0]), .ld_data(byte_w),
    .rd_idx(cyc_q[PAGE_W-1:0]), .rd_data(pb_data), .rd_vld(pb_vld)
  );

  spi_ee_array #(.AW(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(pb_data),
    .raddr(ptr_q), .rdata(rd_q)
  );

  assign byte_w    = {in_q, si_s};
  assign status    = {cfg_q[2], 3'b000, cfg_q[1:0], wel_q, busy_q};
  assign mem_we    = busy_q & ~kind_q & (cyc_q < CW'(PAGE)) & pb_vld;
  assign mem_waddr = {ptr_q[ADDR_W-1:PAGE_W], cyc_q[PAGE_W-1:0]};
  assign cyc_end   = busy_q & (cyc_q == CW'(WC - 1));

  always_comb begin
    st_n = st;  bit_n = bit_q;  in_n = in_q;  ptr_n = ptr_q;
    wrop_n = wrop_q;  done_n = done_q;  wel_n = wel_q;  cfg_n = cfg_q;
    stg_n = stg_q;  busy_n = busy_q;  kind_n = kind_q;  cyc_n = cyc_q;
    tx_n = tx_q;  txc_n = txc_q;  live_n = live_q;
    pb_ld = 1'b0;  pb_clr = cyc_end;  start_arr = 1'b0;  start_sts = 1'b0;

    if (!sel) begin
      st_n = ST_OPC;  bit_n = '0;  in_n = '0;  done_n = 1'b0;
      txc_n = '0;  live_n = 1'b0;
      if (desel_evt) begin
        if (st == ST_SETW) wel_n = 1'b1;
        if (st == ST_CLRW) wel_n = 1'b0;
        start_arr = (st == ST_WR)  & done_q & wel_q & arr_wr_ok & ~busy_q;
        start_sts = (st == ST_SWR) & done_q & wel_q & sts_wr_ok & ~busy_q;
        if (!start_arr && !busy_q) pb_clr = 1'b1;
      end
    end else if (sck_up) begin
      in_n  = byte_w[6:0];
      bit_n = bit_q + 4'd1;
      case (st)
        ST_OPC: if (bit_q == 4'd7) begin
          bit_n = '0;
          if (busy_q && byte_w != OP_SRD) st_n = ST_SKIP;
          else begin
            case (byte_w)
              OP_READ: begin st_n = ST_ADDR; wrop_n = 1'b0; end
              OP_PROG: begin st_n = ST_ADDR; wrop_n = 1'b1; end
              OP_SRD:  st_n = ST_SRD;
              OP_SWR:  st_n = ST_SWR;
              OP_WEN:  st_n = ST_SETW;
              OP_WDIS: st_n = ST_CLRW;
              default: st_n = ST_SKIP;
            endcase
          end
        end
        ST_ADDR: begin
          ptr_n = {ptr_q[ADDR_W-2:0], si_s};
          if (bit_q == 4'd15) begin
            bit_n  = '0;
            st_n   = wrop_q ? ST_WR : ST_RD;
            pb_clr = wrop_q;
          end
        end
        ST_WR: begin
          done_n = 1'b0;
          if (bit_q == 4'd7) begin
            bit_n  = '0;
            pb_ld  = 1'b1;
            done_n = 1'b1;
            ptr_n  = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
          end
        end
        ST_SWR: begin
          if (done_q) begin
            st_n = ST_SKIP;  done_n = 1'b0;
          end else if (bit_q == 4'd7) begin
            stg_n  = {byte_w[7], byte_w[3:2]};
            done_n = 1'b1;
          end
        end
        ST_SETW, ST_CLRW: st_n = ST_SKIP;
        default: ;
      endcase
    end else if (sck_dn && (st == ST_RD || st == ST_SRD)) begin
      txc_n = txc_q + 3'd1;
      if (txc_q == 3'd0) begin
        tx_n   = (st == ST_RD) ? rd_q : status;
        live_n = 1'b1;
        if (st == ST_RD) ptr_n = ptr_q + ADDR_W'(1);
      end else begin
        tx_n = {tx_q[6:0], 1'b0};
      end
    end

    if (busy_q) begin
      cyc_n = cyc_q + CW'(1);
      if (cyc_end) busy_n = 1'b0;
    end
    if (start_arr || start_sts) begin
      busy_n = 1'b1;  cyc_n = '0;  wel_n = 1'b0;  kind_n = start_sts;
      if (start_sts) cfg_n = stg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OPC;  bit_q <= '0;  in_q <= '0;  ptr_q <= '0;
      wrop_q <= 1'b0;  done_q <= 1'b0;  wel_q <= 1'b0;  cfg_q <= '0;
      stg_q <= '0;  busy_q <= 1'b0;  kind_q <= 1'b0;  cyc_q <= '0;
      tx_q <= '0;  txc_q <= '0;  live_q <= 1'b0;
    end else begin
      st <= st_n;  bit_q <= bit_n;  in_q <= in_n;  ptr_q <= ptr_n;
      wrop_q <= wrop_n;  done_q <= done_n;  wel_q <= wel_n;  cfg_q <= cfg_n;
      stg_q <= stg_n;  busy_q <= busy_n;  kind_q <= kind_n;  cyc_q <= cyc_n;
      tx_q <= tx_n;  txc_q <= txc_n;  live_q <= live_n;
    end
  end

  assign so       = tx_q[7];
  assign so_oe    = live_q;
  assign busy     = busy_q;
  assign prot_cfg = cfg_q;

  // R7: a write cycle only ever starts from a deselect event
  a_r7_start_on_desel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(desel_evt));
  // R7: the enable latch is down once the cycle runs
  a_r7_wel_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !wel_q);
  // R5: page number of the write pointer never moves during data loading
  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR && $past(st == ST_WR)) |-> $stable(ptr_q[ADDR_W-1:PAGE_W]));
  // R9: no array access phase while the write cycle runs
  a_r9_no_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (st != ST_RD && st != ST_ADDR && st != ST_WR));
  // R2: the output is enabled only in a data return phase
  a_r2_oe_phase: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (st == ST_RD || st == ST_SRD));
endmodule

// File: tb/spi_ee_slave_tb_top.sv
module spi_ee_slave_tb_top;
  localparam int AW  = 11;
  localparam int PW  = 5;
  localparam int WRC = 2000;
  localparam int H   = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, sck, si, arr_ok, sts_ok;
  logic so, so_oe, busy;
  logic [2:0] prot;
  int   n_chk = 0, n_bad = 0;
  logic oe_seen;
  bit   done = 1'b0;

  spi_ee_slave #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe), .busy(busy),
    .arr_wr_ok(arr_ok), .sts_wr_ok(sts_ok), .prot_cfg(prot)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer_n(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      si = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = so;
      if (so_oe) oe_seen = 1'b1;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_n(tx, 8, rx);
  endtask

  task automatic sel();
    @(negedge clk);
    cs_n = 1'b0;
    oe_seen = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic desel();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, v); desel();
  endtask

  task automatic wr(input logic [15:0] a, input int n, input logic [7:0] b [4]);
    logic [7:0] d;
    sel(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(b[i], d);
    desel();
  endtask

  task automatic rd(input logic [15:0] a, input int n, output logic [7:0] q [4]);
    logic [7:0] d;
    sel(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(8'h00, q[i]);
    desel();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * WRC && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 so_oe", so_oe, 0);
    check("R1 busy", busy, 0);
    check("R1 prot_cfg", prot, 0);
    rdsr(v);
    check("R1 status after reset", v, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] v, d;
    cmd1(8'h06); rdsr(v);
    check("R4 WEL set", v, 8'h02);
    cmd1(8'h04); rdsr(v);
    check("R4 WEL cleared", v, 8'h00);
    sel(); xfer(8'h06, d); xfer_n(8'h00, 1, d); desel(); rdsr(v);
    check("R4 ninth bit voids enable", v, 8'h00);
    sel(); xfer(8'h05, d);
    check("R2 no oe in command", oe_seen, 0);
    xfer(8'h00, v);
    check("R2 oe in data", oe_seen, 1);
    check("R3 status repeat", v, 8'h00);
    desel();
    check("R2 oe off after deselect", so_oe, 0);
  endtask

  task automatic t_write_busy();
    logic [7:0] v, q [4];
    cmd1(8'h06);
    wr(16'h0040, 3, '{8'h11, 8'h22, 8'h33, 8'h00});
    check("R7 busy after commit", busy, 1);
    rdsr(v);
    check("R9 status during cycle", v, 8'h01);
    rd(16'h0040, 2, q);
    check("R9 read ignored in cycle", oe_seen, 0);
    cmd1(8'h06);
    wait_idle();
    rdsr(v);
    check("R7 R9 WEL low after cycle", v, 8'h00);
    rd(16'h0040, 3, q);
    check("R5 byte0", q[0], 8'h11);
    check("R5 byte1", q[1], 8'h22);
    check("R5 byte2", q[2], 8'h33);
  endtask

  task automatic t_duration();
    int cnt;
    cmd1(8'h06);
    wr(16'h0044, 1, '{8'h44, 8'h00, 8'h00, 8'h00});
    cnt = 0;
    while (busy && cnt < 4 * WRC) begin cnt++; @(negedge clk); end
    check("R7 cycle length window", (cnt >= WRC - 20) && (cnt <= WRC), 1);
  endtask

  task automatic t_discard();
    logic [7:0] v, d, q [4];
    cmd1(8'h06);
    sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h40, d);
    xfer(8'h99, d); xfer_n(8'hF0, 3, d); desel();
    check("R6 partial byte no cycle", busy, 0);
    rdsr(v);
    check("R6 WEL kept", v, 8'h02);
    cmd1(8'h04);
    wr(16'h0041, 1, '{8'h77, 8'h00, 8'h00, 8'h00});
    check("R6 no latch no cycle", busy, 0);
    arr_ok = 1'b0;
    cmd1(8'h06);
    wr(16'h0042, 1, '{8'h55, 8'h00, 8'h00, 8'h00});
    check("R6 denied no cycle", busy, 0);
    arr_ok = 1'b1;
    cmd1(8'h04);
    rd(16'h0040, 3, q);
    check("R6 byte 40 intact", q[0], 8'h11);
    check("R6 byte 41 intact", q[1], 8'h22);
    check("R6 byte 42 intact", q[2], 8'h33);
  endtask

  task automatic t_wrap();
    logic [7:0] q [4];
    cmd1(8'h06);
    wr(16'h005E, 4, '{8'hA0, 8'hA1, 8'hA2, 8'hA3});
    wait_idle();
    rd(16'h0040, 3, q);
    check("R5 wrap to page start", q[0], 8'hA2);
    check("R5 wrap second", q[1], 8'hA3);
    check("R5 no spill", q[2], 8'h33);
    rd(16'h005E, 2, q);
    check("R5 page end 5E", q[0], 8'hA0);
    check("R5 page end 5F", q[1], 8'hA1);
  endtask

  task automatic t_roll();
    logic [7:0] q [4];
    cmd1(8'h06);
    wr(16'h07FF, 1, '{8'hC1, 8'h00, 8'h00, 8'h00});
    wait_idle();
    cmd1(8'h06);
    wr(16'h0000, 1, '{8'hC2, 8'h00, 8'h00, 8'h00});
    wait_idle();
    rd(16'h07FF, 2, q);
    check("R8 top byte", q[0], 8'hC1);
    check("R8 rollover to zero", q[1], 8'hC2);
    rd(16'hF840, 1, q);
    check("R8 upper address bits ignored", q[0], 8'hA2);
  endtask

  task automatic t_cfg();
    logic [7:0] v, d;
    cmd1(8'h06);
    sel(); xfer(8'h01, d); xfer(8'h8C, d); desel();
    check("R10 cfg write runs a cycle", busy, 1);
    wait_idle();
    check("R10 prot_cfg loaded", prot, 3'b111);
    rdsr(v);
    check("R3 R10 status fields", v, 8'h8C);
    sts_ok = 1'b0;
    cmd1(8'h06);
    sel(); xfer(8'h01, d); xfer(8'h00, d); desel();
    check("R10 denied no cycle", busy, 0);
    check("R10 denied cfg kept", prot, 3'b111);
    sts_ok = 1'b1;
    sel(); xfer(8'h01, d); xfer(8'h00, d); xfer(8'h00, d); desel();
    check("R10 two bytes rejected", prot, 3'b111);
    sel(); xfer(8'h01, d); xfer(8'h00, d); desel();
    wait_idle();
    check("R10 cfg cleared", prot, 3'b000);
  endtask

  task automatic t_unknown();
    logic [7:0] v, d;
    sel(); xfer(8'hFF, d); xfer(8'h06, d); desel();
    rdsr(v);
    check("R11 enable after bad command ignored", v, 8'h00);
    sel(); xfer(8'hAB, d); xfer(8'h05, d); xfer(8'h00, d); desel();
    check("R11 no output after bad command", oe_seen, 0);
  endtask

  task automatic t_power();
    logic [7:0] v, d;
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    oe_seen = 1'b0;
    xfer(8'h05, d); xfer(8'h00, d);
    check("R1 low CS at reset ignored", oe_seen, 0);
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
    rdsr(v);
    check("R1 works after CS toggle", oe_seen, 1);
    check("R1 status after second reset", v, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
    arr_ok = 1'b1; sts_ok = 1'b1; oe_seen = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_latch();
    t_write_busy();
    t_duration();
    t_discard();
    t_wrap();
    t_roll();
    t_cfg();
    t_unknown();
    t_power();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule